// File: doc/BRIEF.md
# Boot Memory Remap Decoder

This block decodes the address of each bus access into one of four memory selects. Three of them are active-low chip selects for static boot devices: a disk-on-chip part, a NOR flash and an expansion memory. The fourth is an active-high select for SDRAM. After reset, the selected boot device is aliased into the lowest 64 MiB of the address space, so the processor fetches its first instructions from non-volatile storage. Once boot code has brought up SDRAM, it clears two remap flags, and SDRAM then takes over address zero.

A second 64 MiB window at 0x34000000 always reaches the boot device, whatever the remap state. Boot code can jump into this window before it removes the low alias. Two strap inputs choose the boot device. The block captures them once per reset and keeps them fixed until the next reset.

The decode path is combinational from `req` and `addr`. The only state is the captured strap code, a capture-done bit and the two remap flags.

Top module: `boot_remap_decoder`

## Requirements
- R1: The block samples `strap_sel` on the first rising clock edge after `rst_n` is released. `strap_sel[0]` is the first switch and `strap_sel[1]` is the second, where ON means 1. Later changes to `strap_sel` have no effect until the next reset.
- R2: The captured code selects the boot device as follows. 2'b00 selects disk-on-chip (`doc_cs_n`), 2'b01 selects NOR flash (`nor_cs_n`) and 2'b11 selects expansion memory (`exp_cs_n`).
- R3: Out of reset, `remap_flags` reads 2'b11. Bit 0 is the device remap flag and bit 1 is the external remap flag.
- R4: While either remap flag is 1, a request to 0x00000000–0x03FFFFFF asserts the chip select of the boot device.
- R5: When both remap flags are 0, a request to 0x00000000–0x03FFFFFF asserts `sdram_sel` and no chip select.
- R6: A request to 0x34000000–0x37FFFFFF asserts the chip select of the boot device, whatever the remap flags are.
- R7: A control write with `ctl_wbit`=0 clears a flag. The address 0x10000000 clears bit 0 and the address 0x04 above it (0x10000004) clears bit 1. A write with `ctl_wbit`=1, or to any other address, leaves both flags unchanged. Software can never set a flag.
- R8: With the reserved code 2'b10, a request that hits the boot device asserts no select and raises `decode_err`.
- R9: A request outside both windows asserts no select and raises `decode_err`. With `req` low, all selects and `decode_err` are idle.
- R10: At most one of the four selects is active at any time.
- R11: From the release of reset until the strap code has been captured, all selects and `decode_err` stay idle, even while `req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_sel | input | 2 | Boot-select strap pins |
| req | input | 1 | An access is presented this cycle |
| addr | input | 32 | Access address |
| ctl_we | input | 1 | Remap control write strobe |
| ctl_addr | input | 32 | Remap control write address |
| ctl_wbit | input | 1 | Written value; 0 clears the addressed flag |
| doc_cs_n | output | 1 | Disk-on-chip select, active low |
| nor_cs_n | output | 1 | NOR flash select, active low |
| exp_cs_n | output | 1 | Expansion memory select, active low |
| sdram_sel | output | 1 | SDRAM select, active high |
| decode_err | output | 1 | Request hit no valid target |
| remap_flags | output | 2 | {external, device} remap flags |

## Verification
The hardest case to reach is the one where only one remap flag is still set, after the other has been cleared. From the outside this state looks the same as full remap, and it is exactly where an AND-instead-of-OR mistake would hide. The bench reaches it with a single clearing write. For even codes that write goes to the external flag first, and for odd codes to the device flag first. It then sweeps all boundary addresses in that half-cleared state before clearing the second flag.

The strap hold is exercised by inverting the straps straight after capture. Each of the four codes gets its own reset.

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder #(
  parameter logic [31:0] LOW_BASE      = 32'h0000_0000,
  parameter logic [31:0] LOW_SIZE      = 32'h0400_0000,
  parameter logic [31:0] ALIAS_BASE    = 32'h3400_0000,
  parameter logic [31:0] ALIAS_SIZE    = 32'h0400_0000,
  parameter logic [31:0] DEV_CTRL_ADDR = 32'h1000_0000,
  parameter logic [31:0] EXT_CTRL_ADDR = 32'h1000_0004
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  strap_sel,
  input  logic        req,
  input  logic [31:0] addr,
  input  logic        ctl_we,
  input  logic [31:0] ctl_addr,
  input  logic        ctl_wbit,
  output logic        doc_cs_n,
  output logic        nor_cs_n,
  output logic        exp_cs_n,
  output logic        sdram_sel,
  output logic        decode_err,
  output logic [1:0]  remap_flags
);

  localparam logic [1:0] CODE_DOC = 2'b00;
  localparam logic [1:0] CODE_NOR = 2'b01;
  localparam logic [1:0] CODE_RSV = 2'b10;
  localparam logic [1:0] CODE_EXP = 2'b11;

  logic [1:0] boot_q;
  logic       started;
  logic [1:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q  <= CODE_DOC;
      started <= 1'b0;
    end else if (!started) begin
      boot_q  <= strap_sel;
      started <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= 2'b11;
    end else if (ctl_we && !ctl_wbit) begin
      if (ctl_addr == DEV_CTRL_ADDR) flags[0] <= 1'b0;
      if (ctl_addr == EXT_CTRL_ADDR) flags[1] <= 1'b0;
    end
  end

  logic live, in_low, in_alias, remap, boot_hit, sdram_hit;

  assign live      = req && started;
  assign in_low    = (addr - LOW_BASE) < LOW_SIZE;
  assign in_alias  = (addr - ALIAS_BASE) < ALIAS_SIZE;
  assign remap     = |flags;
  assign boot_hit  = live && (in_alias || (in_low && remap));
  assign sdram_hit = live && in_low && !remap && !in_alias;

  assign doc_cs_n    = !(boot_hit && boot_q == CODE_DOC);
  assign nor_cs_n    = !(boot_hit && boot_q == CODE_NOR);
  assign exp_cs_n    = !(boot_hit && boot_q == CODE_EXP);
  assign sdram_sel   = sdram_hit;
  assign decode_err  = (live && !in_low && !in_alias) || (boot_hit && boot_q == CODE_RSV);
  assign remap_flags = flags;

  assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!doc_cs_n, !nor_cs_n, !exp_cs_n, sdram_sel}));

  assert_flags_never_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(flags[0]) && !$rose(flags[1]));

  assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> $stable(boot_q));

  assert_idle_before_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (doc_cs_n && nor_cs_n && exp_cs_n && !sdram_sel && !decode_err));

  assert_sdram_only_unmapped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sdram_sel |-> (flags == 2'b00));

  assert_alias_hits_boot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && in_alias && boot_q != CODE_RSV) |-> (!doc_cs_n || !nor_cs_n || !exp_cs_n));

  assert_err_excludes_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err |-> (doc_cs_n && nor_cs_n && exp_cs_n && !sdram_sel));

endmodule

// File: tb/sim_boot_remap_decoder.sv
`timescale 1ns/1ps
module sim_boot_remap_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap_sel = 2'b00;
  logic        req = 1'b0;
  logic [31:0] addr = 32'h0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_addr = 32'h0;
  logic        ctl_wbit = 1'b1;
  logic        doc_cs_n, nor_cs_n, exp_cs_n, sdram_sel, decode_err;
  logic [1:0]  remap_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  boot_remap_decoder u0 (
    .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .req(req), .addr(addr),
    .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wbit(ctl_wbit),
    .doc_cs_n(doc_cs_n), .nor_cs_n(nor_cs_n), .exp_cs_n(exp_cs_n),
    .sdram_sel(sdram_sel), .decode_err(decode_err), .remap_flags(remap_flags)
  );

  localparam int NADDR = 10;
  localparam logic [31:0] SWEEP [NADDR] = '{
    32'h0000_0000, 32'h0123_4568, 32'h03FF_FFFC, 32'h0400_0000, 32'h1000_0000,
    32'h33FF_FFFC, 32'h3400_0000, 32'h37FF_FFFC, 32'h3800_0000, 32'hFFFF_FFFC };

  function automatic logic [4:0] expect_vec(input logic [1:0] code, input logic remap,
                                            input logic r, input logic [31:0] a);
    logic low, al, boot;
    logic [4:0] v;
    low  = a < 32'h0400_0000;
    al   = (a >= 32'h3400_0000) && (a < 32'h3800_0000);
    boot = r && (al || (low && remap));
    v = 5'b11100;
    if (boot && code == 2'b00) v[4] = 1'b0;
    if (boot && code == 2'b01) v[3] = 1'b0;
    if (boot && code == 2'b11) v[2] = 1'b0;
    if (r && low && !remap) v[1] = 1'b1;
    if ((r && !low && !al) || (boot && code == 2'b10)) v[0] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic sweep(input logic [1:0] code, input string tag);
    logic remap;
    remap = |remap_flags;
    for (int i = 0; i < NADDR; i++) begin
      @(negedge clk);
      req = 1'b1; addr = SWEEP[i];
      #1;
      check($sformatf("%s code=%0d addr=%h", tag, code, SWEEP[i]),
            {27'd0, doc_cs_n, nor_cs_n, exp_cs_n, sdram_sel, decode_err},
            {27'd0, expect_vec(code, remap, 1'b1, SWEEP[i])});
    end
    @(negedge clk);
    req = 1'b0; addr = 32'h0;
    #1;
    check("R9 idle with req low", {27'd0, doc_cs_n, nor_cs_n, exp_cs_n, sdram_sel, decode_err},
          {27'd0, 5'b11100});
  endtask

  task automatic ctl_write(input logic [31:0] a, input logic b);
    @(negedge clk);
    ctl_we = 1'b1; ctl_addr = a; ctl_wbit = b;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wbit = 1'b1;
    #1;
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      logic [1:0] code;
      code = c[1:0];
      @(negedge clk);
      rst_n = 1'b0; req = 1'b0; strap_sel = code;
      @(negedge clk);
      rst_n = 1'b1; req = 1'b1; addr = 32'h3400_0000;
      #1;
      check("R11 idle before capture", {27'd0, doc_cs_n, nor_cs_n, exp_cs_n, sdram_sel, decode_err},
            {27'd0, 5'b11100});
      @(posedge clk);
      #1;
      strap_sel = ~code;
      req = 1'b0;
      check("R3 flags after reset", {30'd0, remap_flags}, 32'd3);
      sweep(code, "R1 R2 R4 R6 R8 R9 full remap");
      if (code[0]) begin
        ctl_write(32'h1000_0000, 1'b0);
        check("R7 clear device flag", {30'd0, remap_flags}, 32'd2);
      end else begin
        ctl_write(32'h1000_0004, 1'b0);
        check("R7 clear external flag", {30'd0, remap_flags}, 32'd1);
      end
      sweep(code, "R4 one flag left");
      ctl_write(32'h1000_0008, 1'b0);
      check("R7 other address ignored", {30'd0, remap_flags}, code[0] ? 32'd2 : 32'd1);
      ctl_write(code[0] ? 32'h1000_0004 : 32'h1000_0000, 1'b1);
      check("R7 write of one ignored", {30'd0, remap_flags}, code[0] ? 32'd2 : 32'd1);
      ctl_write(code[0] ? 32'h1000_0004 : 32'h1000_0000, 1'b0);
      check("R7 both cleared", {30'd0, remap_flags}, 32'd0);
      sweep(code, "R5 R6 R10 unmapped");
      ctl_write(32'h1000_0000, 1'b1);
      ctl_write(32'h1000_0004, 1'b1);
      check("R7 cannot set", {30'd0, remap_flags}, 32'd0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule